// File: doc/BRIEF.md
# Audio Clock Generator Chain

This block builds the three clocks of a serial audio link from one of two source clocks: a root (master) clock for the codec, a bit clock and a left/right word-select clock. Both source clocks arrive as single-cycle tick strobes in the block's system clock domain. One select bit picks which strobe feeds the chain. An optional prescaler divides the chosen ticks, and the root clock toggles on every prescaled tick. The bit clock is a further division of the prescaled ticks, and the word-select clock is a division of the bit clock.

The root clock ratio is picked from four multiples of the frame rate and the bit clock ratio from another four. The bit clock half period, counted in prescaled ticks, equals the root ratio divided by the bit ratio. A pair whose quotient is not an integer is flagged and silences the bit and word-select clocks. In master mode the block drives the bit and word-select pins. In slave mode it releases them and reports the level of the external word-select line through a two-stage synchroniser, so that software can line up with the far end. A direction control decides whether the root clock pin is driven.

Top module: `audio_clkgen`

## Requirements
- R1: When `src_sel_i` is 1 the chain counts `aud_tick_i` strobes and when it is 0 it counts `pclk_tick_i` strobes; ticks of the other source have no effect.
- R2: With `psr_en_i` at 0 the prescaler passes every source tick through, so `root_clk_o` toggles on each selected tick.
- R3: With `psr_en_i` at 1 the prescaler passes one tick in every `psr_val_i` + 1 selected ticks.
- R4: A new prescaler value or enable is taken up only at the prescaler's terminal count; the period that is running when it changes completes at the old length.
- R5: Root code 0/1/2/3 selects 256/384/512/768 and bit code 0/1/2/3 selects 16/24/32/48 times the frame rate; in master mode `bclk_o` toggles every (root ratio / bit ratio) prescaled ticks.
- R6: A pair whose root ratio is not a whole multiple of the bit ratio raises `cfg_bad_o`, and `bclk_o` and `lr_o` are then held low.
- R7: `lr_o` starts low and toggles only together with a falling edge of `bclk_o`, once every (bit ratio / 2) bit clock periods, giving one full word-select period per frame.
- R8: `master_i` at 1 sets `bclk_oe_o` and `lr_oe_o`; at 0 both are low and `bclk_o` and `lr_o` are held low from the next clock.
- R9: In slave mode `lr_level_o` equals `lr_i` delayed by two clocks; in master mode it equals `lr_o`.
- R10: `root_oe_o` is the inverse of `cdclk_in_i`: the root clock pin is driven only when it is not configured as an input.
- R11: During reset `root_clk_o`, `bclk_o` and `lr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk_tick_i | input | 1 | Tick strobe of the peripheral bus source |
| aud_tick_i | input | 1 | Tick strobe of the audio bus source |
| src_sel_i | input | 1 | Source select, 1 = audio bus source |
| psr_en_i | input | 1 | Prescaler enable |
| psr_val_i | input | PSR_W | Prescaler value, divide by value + 1 |
| root_code_i | input | 2 | Root clock ratio code |
| bit_code_i | input | 2 | Bit clock ratio code |
| master_i | input | 1 | 1 = drive bit and word-select clocks |
| cdclk_in_i | input | 1 | 1 = root clock pin is an input |
| lr_i | input | 1 | External word-select line (slave mode) |
| root_clk_o | output | 1 | Root clock |
| root_oe_o | output | 1 | Root clock pin drive enable |
| bclk_o | output | 1 | Bit clock |
| bclk_oe_o | output | 1 | Bit clock pin drive enable |
| lr_o | output | 1 | Word-select clock |
| lr_oe_o | output | 1 | Word-select pin drive enable |
| lr_level_o | output | 1 | Current word-select level |
| cfg_bad_o | output | 1 | Ratio pair is not an integer division |

## Verification
Every clock output is a register updated on the edge at which a prescaled tick arrives, so the clock-rate results are checked as intervals, in system clocks, between successive toggles seen at the falling edge; the absolute one-clock latency then cancels, and the first intervals after each reconfiguration are discarded because they straddle the change. The prescaler reload rule is checked by synchronising to a root clock toggle and changing the value right there, expecting one old-length interval before the new one. The slave level is due exactly two clocks after `lr_i` changes and is sampled after one and after two rising edges; drive enables and the bad-pair flag follow their inputs in the same cycle, and the silencing of invalid pairs and of slave mode is checked one clock after the change.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // width of the bit clock half-period counter (largest quotient 48)
  localparam int HALF_W = 6;
  // width of the bit slot counter within one word-select half (largest 24)
  localparam int SLOT_W = 5;

  // root clock multiple of the frame rate
  function automatic logic [9:0] root_mult(input logic [1:0] code);
    case (code)
      2'd0:    return 10'd256;
      2'd1:    return 10'd384;
      2'd2:    return 10'd512;
      default: return 10'd768;
    endcase
  endfunction

  // bit clock multiple of the frame rate
  function automatic logic [5:0] bit_mult(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      2'd2:    return 6'd32;
      default: return 6'd48;
    endcase
  endfunction

  // half period of the bit clock in prescaled ticks, 0 when not integral
  function automatic logic [HALF_W-1:0] half_ticks(input logic [1:0] rcode,
                                                   input logic [1:0] bcode);
    logic [9:0] r;
    logic [9:0] b;
    r = root_mult(rcode);
    b = {4'd0, bit_mult(bcode)};
    if ((r % b) == 10'd0) return HALF_W'(r / b);
    else return '0;
  endfunction

endpackage

// File: rtl/audio_clkgen_prescaler.sv
module audio_clkgen_prescaler #(
  parameter int PSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PSR_W-1:0] val_i,
  output logic             tick_o
);

  logic [PSR_W-1:0] cnt_q;
  logic [PSR_W-1:0] val_q;
  logic             en_q;
  logic             term;

  // terminal count: every tick when bypassed, else when count reaches value
  assign term   = !en_q || (cnt_q == val_q);
  assign tick_o = tick_i && term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= '0;
      en_q  <= 1'b0;
    end else if (tick_i) begin
      if (term) begin
        cnt_q <= '0;
        val_q <= val_i;
        en_q  <= en_i;
      end else begin
        cnt_q <= cnt_q + PSR_W'(1);
      end
    end
  end

  // R4: the divide setting is only replaced at a terminal count
  assert_reload_at_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((val_q != $past(val_q)) || (en_q != $past(en_q))) |-> $past(tick_o));

  // R3: the running count never passes the active value
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (cnt_q <= val_q));

endmodule

// File: rtl/audio_clkgen_bitdiv.sv
module audio_clkgen_bitdiv
  import audio_clkgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [1:0] root_code_i,
  input  logic [1:0] bit_code_i,
  output logic       bclk_o,
  output logic       lr_o,
  output logic       bad_o
);

  logic [HALF_W-1:0] half;
  logic [SLOT_W-1:0] slots;
  logic [HALF_W-1:0] hcnt_q;
  logic [SLOT_W-1:0] scnt_q;
  logic              bclk_q;
  logic              lr_q;
  logic              bad;
  logic              active;

  assign half   = half_ticks(root_code_i, bit_code_i);
  assign slots  = SLOT_W'(bit_mult(bit_code_i) >> 1);
  assign bad    = (half == '0);
  assign active = run_i && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      scnt_q <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else if (!active) begin
      hcnt_q <= '0;
      scnt_q <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else if (tick_i) begin
      if (hcnt_q >= half - HALF_W'(1)) begin
        hcnt_q <= '0;
        bclk_q <= !bclk_q;
        if (bclk_q) begin
          // falling edge of the bit clock: count a bit slot
          if (scnt_q >= slots - SLOT_W'(1)) begin
            scnt_q <= '0;
            lr_q   <= !lr_q;
          end else begin
            scnt_q <= scnt_q + SLOT_W'(1);
          end
        end
      end else begin
        hcnt_q <= hcnt_q + HALF_W'(1);
      end
    end
  end

  assign bclk_o = bclk_q;
  assign lr_o   = lr_q;
  assign bad_o  = bad;

  // R7: word select moves only with a falling bit clock edge
  assert_lr_on_bclk_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_q != $past(lr_q)) |-> ($past(bclk_q) && !bclk_q));

  // R6: an invalid ratio pair silences both clocks
  assert_invalid_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (!bclk_q && !lr_q));

  // R5: the bit clock holds between prescaled ticks
  assert_bclk_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && active) |=> $stable(bclk_q));

endmodule

// File: rtl/audio_clkgen_lrsync.sv
module audio_clkgen_lrsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lr_i,
  output logic lr_o
);

  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= lr_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], lr_i};
      end
    end
  endgenerate

  assign lr_o = sh_q[STAGES-1];

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int PSR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk_tick_i,
  input  logic             aud_tick_i,
  input  logic             src_sel_i,
  input  logic             psr_en_i,
  input  logic [PSR_W-1:0] psr_val_i,
  input  logic [1:0]       root_code_i,
  input  logic [1:0]       bit_code_i,
  input  logic             master_i,
  input  logic             cdclk_in_i,
  input  logic             lr_i,
  output logic             root_clk_o,
  output logic             root_oe_o,
  output logic             bclk_o,
  output logic             bclk_oe_o,
  output logic             lr_o,
  output logic             lr_oe_o,
  output logic             lr_level_o,
  output logic             cfg_bad_o
);

  logic src_tick;
  logic ptick;
  logic root_q;
  logic bclk_w;
  logic lr_w;
  logic lr_sync;

  assign src_tick = src_sel_i ? aud_tick_i : pclk_tick_i;

  audio_clkgen_prescaler #(.PSR_W(PSR_W)) u_psr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (src_tick),
    .en_i   (psr_en_i),
    .val_i  (psr_val_i),
    .tick_o (ptick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     root_q <= 1'b0;
    else if (ptick) root_q <= !root_q;
  end

  audio_clkgen_bitdiv u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (ptick),
    .run_i       (master_i),
    .root_code_i (root_code_i),
    .bit_code_i  (bit_code_i),
    .bclk_o      (bclk_w),
    .lr_o        (lr_w),
    .bad_o       (cfg_bad_o)
  );

  audio_clkgen_lrsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .lr_i  (lr_i),
    .lr_o  (lr_sync)
  );

  assign root_clk_o = root_q;
  assign root_oe_o  = !cdclk_in_i;
  assign bclk_o     = bclk_w;
  assign lr_o       = lr_w;
  assign bclk_oe_o  = master_i;
  assign lr_oe_o    = master_i;
  assign lr_level_o = master_i ? lr_w : lr_sync;

  // R1: with the audio source selected, a cycle without its tick leaves the root clock alone
  assert_aud_src_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i && !aud_tick_i) |=> $stable(root_clk_o));

  // R1: likewise for the peripheral source
  assert_pclk_src_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel_i && !pclk_tick_i) |=> $stable(root_clk_o));

  // R8: slave mode releases and silences the bit clock
  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> (!bclk_o && !lr_o));

endmodule

// File: tb/audio_clkgen_tb_top.sv
`timescale 1ns/1ps
module audio_clkgen_tb_top;

  localparam int PSR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pclk_tick;
  logic             aud_tick;
  logic             src_sel;
  logic             psr_en;
  logic [PSR_W-1:0] psr_val;
  logic [1:0]       root_code;
  logic [1:0]       bit_code;
  logic             master;
  logic             cdclk_in;
  logic             lr_in;
  logic             root_clk, root_oe, bclk, bclk_oe, lr, lr_oe, lr_level, cfg_bad;

  always #2.5 clk = ~clk;

  audio_clkgen #(.PSR_W(PSR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pclk_tick_i(pclk_tick), .aud_tick_i(aud_tick),
    .src_sel_i(src_sel), .psr_en_i(psr_en), .psr_val_i(psr_val),
    .root_code_i(root_code), .bit_code_i(bit_code), .master_i(master),
    .cdclk_in_i(cdclk_in), .lr_i(lr_in), .root_clk_o(root_clk), .root_oe_o(root_oe),
    .bclk_o(bclk), .bclk_oe_o(bclk_oe), .lr_o(lr), .lr_oe_o(lr_oe),
    .lr_level_o(lr_level), .cfg_bad_o(cfg_bad)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  int     ph = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // audio source ticks once every three clocks, peripheral source every clock
  always @(negedge clk) ph <= (ph == 2) ? 0 : ph + 1;
  assign aud_tick  = (ph == 0);
  assign pclk_tick = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard: expected toggle intervals of one watched output
  int     exp_q[$];
  int     mon_sel = 0;
  int     mon_skip = 0;
  string  mon_tag = "R11";
  logic   last_v = 1'b0;
  longint last_t = 0;
  event   tog_ev;

  function automatic logic watched();
    case (mon_sel)
      0:       return root_clk;
      1:       return bclk;
      default: return lr;
    endcase
  endfunction

  always @(negedge clk) begin
    logic v;
    int   e;
    v = watched();
    if (rst_n && v !== last_v) begin
      if (mon_skip > 0) mon_skip--;
      else if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk((cyc - last_t) == e, mon_tag, "toggle interval", cyc - last_t, e);
        if (mon_sel == 2) chk(bclk == 1'b0, "R7", "bclk low when lr moves", bclk, 0);
      end
      last_t = cyc;
      last_v = v;
      -> tog_ev;
    end
  end

  task automatic wait_drain(input string tag);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
    end
    if (exp_q.size() > 0) begin
      chk(1'b0, tag, "scoreboard drain timeout", exp_q.size(), 0);
      exp_q.delete();
    end
  endtask

  task automatic run_expect(input int sel, input int skip, input int n,
                            input int val, input string tag);
    @(posedge clk); #1;
    exp_q.delete();
    mon_sel  = sel;
    mon_skip = skip;
    mon_tag  = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(val);
    wait_drain(tag);
  endtask

  task automatic bclk_case(input logic [1:0] rc, input logic [1:0] bc, input int half);
    @(posedge clk); #1;
    root_code = rc;
    bit_code  = bc;
    @(negedge clk);
    chk(cfg_bad == 1'b0, "R5", "valid pair flag", cfg_bad, 0);
    run_expect(1, 2, 3, half, "R5");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    src_sel   = 1'b0;
    psr_en    = 1'b0;
    psr_val   = '0;
    root_code = 2'd0;
    bit_code  = 2'd2;
    master    = 1'b1;
    cdclk_in  = 1'b0;
    lr_in     = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(root_clk == 1'b0, "R11", "root low in reset", root_clk, 0);
    chk(bclk == 1'b0, "R11", "bclk low in reset", bclk, 0);
    chk(lr == 1'b0, "R11", "lr low in reset", lr, 0);
    rst_n = 1'b1;

    // R2 pass-through: root toggles every selected tick
    run_expect(0, 2, 4, 1, "R2");
    // R1 audio source: ticks every three clocks
    @(posedge clk); #1; src_sel = 1'b1;
    run_expect(0, 2, 4, 3, "R1");
    @(posedge clk); #1; src_sel = 1'b0;
    // R3 divide by value + 1
    @(posedge clk); #1; psr_en = 1'b1; psr_val = 8'd4;
    run_expect(0, 3, 4, 5, "R3");
    @(posedge clk); #1; psr_val = 8'd9;
    run_expect(0, 3, 2, 10, "R3");
    // R4 change right after a terminal count: old length once, then new
    @(tog_ev);
    psr_val  = 8'd1;
    exp_q.delete();
    mon_skip = 0;
    mon_tag  = "R4";
    exp_q.push_back(10);
    exp_q.push_back(2);
    exp_q.push_back(2);
    wait_drain("R4");
    @(posedge clk); #1; psr_en = 1'b0; psr_val = '0;

    // R5 bit clock half periods in system clocks (one prescaled tick each)
    bclk_case(2'd0, 2'd2, 8);
    bclk_case(2'd1, 2'd1, 16);
    bclk_case(2'd3, 2'd3, 16);
    bclk_case(2'd2, 2'd0, 32);

    // R7 one word-select toggle every root-ratio clocks
    @(posedge clk); #1; root_code = 2'd0; bit_code = 2'd2;
    run_expect(2, 2, 2, 256, "R7");
    @(posedge clk); #1; root_code = 2'd1; bit_code = 2'd3;
    run_expect(2, 2, 2, 384, "R7");
    @(negedge clk);
    chk(lr_level == lr, "R9", "master level follows lr", lr_level, lr);

    // R6 invalid pairs
    @(posedge clk); #1; mon_sel = 0; root_code = 2'd0; bit_code = 2'd1;
    @(negedge clk);
    chk(cfg_bad == 1'b1, "R6", "256/24 flagged", cfg_bad, 1);
    begin
      int hi = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (bclk || lr) hi++;
      end
      chk(hi == 0, "R6", "clocks quiet when invalid", hi, 0);
    end
    @(posedge clk); #1; root_code = 2'd2; bit_code = 2'd3;
    @(negedge clk);
    chk(cfg_bad == 1'b1, "R6", "512/48 flagged", cfg_bad, 1);

    // R10 root pin direction
    @(posedge clk); #1; cdclk_in = 1'b1;
    @(negedge clk);
    chk(root_oe == 1'b0, "R10", "root pin input", root_oe, 0);
    @(posedge clk); #1; cdclk_in = 1'b0;
    @(negedge clk);
    chk(root_oe == 1'b1, "R10", "root pin output", root_oe, 1);

    // R8 slave mode releases pins, clocks go low
    @(posedge clk); #1; root_code = 2'd0; bit_code = 2'd0; master = 1'b1;
    repeat (40) @(posedge clk);
    #1; master = 1'b0;
    @(negedge clk);
    chk(bclk_oe == 1'b0, "R8", "bclk released", bclk_oe, 0);
    chk(lr_oe == 1'b0, "R8", "lr released", lr_oe, 0);
    chk(bclk == 1'b0, "R8", "bclk low in slave", bclk, 0);

    // R9 slave level through two-stage sync
    @(negedge clk);
    chk(lr_level == 1'b0, "R9", "slave level idle", lr_level, 0);
    lr_in = 1'b1;
    @(negedge clk);
    chk(lr_level == 1'b0, "R9", "level after one edge", lr_level, 0);
    @(negedge clk);
    chk(lr_level == 1'b1, "R9", "level after two edges", lr_level, 1);
    lr_in = 1'b0;
    repeat (2) @(negedge clk);
    chk(lr_level == 1'b0, "R9", "level follows fall", lr_level, 0);

    @(posedge clk); #1; master = 1'b1;
    @(negedge clk);
    chk(bclk_oe == 1'b1 && lr_oe == 1'b1, "R8", "master drives pins",
        {bclk_oe, lr_oe}, 3);

    finish_run();
  end

endmodule